// File: doc/BRIEF.md
# Wave Lane Shift and Broadcast Network

This block sits in front of a vector ALU operand port and moves 32-bit values between the lanes of a wave. A wave holds 64 lanes, or only its lower 32 lanes in narrow mode. A 3-bit operation code selects one of eight moves:

- pass-through;
- a shift right, a shift left or a rotate right by 0 to 15 lanes, confined to each 16-lane row;
- a copy of the last lane of each row into the row after it;
- a copy of lane 31 into the upper two rows;
- a one-lane shift right or a one-lane rotate left across the whole wave.

Every lane also gets a flag that says whether it received a value from a source lane. A lane that has no source reads either zero or its old destination value, chosen by an input. The result is registered, so it appears one cycle after the request. Chaining passes through the network, each followed by an ALU add or max, builds a log-step reduction or prefix scan. A 64-lane wave needs six such steps.

Top module: `lane_xfer_net`

## Requirements
- R1: The outputs are registered with a latency of one cycle. `out_vld` is `in_vld` delayed by one clock. A synchronous reset clears `out_vld`, `res` and `lane_ok` to zero.
- R2: With op=0 (pass), every active lane returns its own input and is flagged valid.
- R3: With op=1 (row shift right by `amt`), the lane at row position p takes the value of position p−amt in the same row. Positions below amt have no source. Row positions are lane mod 16.
- R4: With op=2 (row shift left by `amt`), the lane at position p takes position p+amt in the same row. Positions above 15−amt have no source.
- R5: With op=3 (row rotate right by `amt`), position p takes position (p−amt) mod 16 of the same row, and every active lane is valid.
- R6: With op=4, every lane of row r≥1 takes lane 16·r−1. The lanes of row 0 have no source.
- R7: With op=5, every lane of rows 2 and 3 takes lane 31. The lanes of rows 0 and 1 have no source.
- R8: With op=6 (wave shift right by one), lane i takes lane i−1, and lane 0 has no source.
- R9: With op=7 (wave rotate left by one), lane i takes lane i+1, and the top active lane takes lane 0.
- R10: A lane with no source has `lane_ok`=0. Its result is zero when `bound_zero`=1 and its `old_dst` value when `bound_zero`=0. Every lane with a source has `lane_ok`=1.
- R11: With `narrow`=1, lanes 32 to 63 output zero with `lane_ok`=0, and their inputs have no effect on lanes 0 to 31. Wave moves wrap at lane 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request valid |
| op_code | input | 3 | Move select, 0 to 7 as listed in R2 to R9 |
| amt | input | 4 | Lane count for the row moves |
| narrow | input | 1 | 1 selects 32-lane mode |
| bound_zero | input | 1 | 1: lanes with no source read zero; 0: they keep `old_dst` |
| src | input | 2048 | Source value, 32 bits per lane, lane 0 in the low bits |
| old_dst | input | 2048 | Previous destination value per lane |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| res | output | 2048 | Moved vector |
| lane_ok | output | 64 | Per-lane flag that a source existed |

## Verification
The network holds no state beyond its output register, so a wrong source choice or a wrong edge rule shows up in `res` or `lane_ok` in the cycle after the request that exposes it. A misplaced row boundary or wrap point shows only for particular shift amounts and only in specific lanes. For that reason every move is driven with the extreme amounts and with random data in both wave widths. Each lane's result is compared separately from its valid flag, so a fill value that is wrong but correctly flagged is still caught.

// File: rtl/lxn_pkg.sv
package lxn_pkg;

    localparam int ROW_LANES = 16;
    localparam int IDX_W     = 7;

    typedef enum logic [2:0] {
        OP_PASS     = 3'd0,
        OP_ROW_SHR  = 3'd1,
        OP_ROW_SHL  = 3'd2,
        OP_ROW_ROR  = 3'd3,
        OP_BC_ROWND = 3'd4,
        OP_BC_L31   = 3'd5,
        OP_WAVE_SHR = 3'd6,
        OP_WAVE_ROL = 3'd7
    } xfer_op_e;

    typedef struct packed {
        logic             has;
        logic [IDX_W-1:0] idx;
    } lane_pick_t;

    // Source lane for one destination lane; has=0 means no source.
    function automatic lane_pick_t pick_source(int lane, xfer_op_e op,
                                               logic [3:0] amt, logic narrow,
                                               int lanes);
        int row;
        int pos;
        int top;
        int n;
        int j;
        lane_pick_t r;
        row = lane / ROW_LANES;
        pos = lane % ROW_LANES;
        top = narrow ? (lanes / 2 - 1) : (lanes - 1);
        n   = int'(amt);
        j   = -1;
        case (op)
            OP_PASS:     j = lane;
            OP_ROW_SHR:  j = (pos >= n) ? lane - n : -1;
            OP_ROW_SHL:  j = (pos + n < ROW_LANES) ? lane + n : -1;
            OP_ROW_ROR:  j = row * ROW_LANES + ((pos - n + ROW_LANES) % ROW_LANES);
            OP_BC_ROWND: j = (row >= 1) ? row * ROW_LANES - 1 : -1;
            OP_BC_L31:   j = (row >= 2) ? 2 * ROW_LANES - 1 : -1;
            OP_WAVE_SHR: j = (lane >= 1) ? lane - 1 : -1;
            OP_WAVE_ROL: j = (lane == top) ? 0 : lane + 1;
            default:     j = lane;
        endcase
        r.has = (j >= 0);
        r.idx = r.has ? IDX_W'(j) : '0;
        return r;
    endfunction

endpackage

// File: rtl/lxn_lane_mux.sv
module lxn_lane_mux
    import lxn_pkg::*;
#(
    parameter int LANES = 64,
    parameter int DW    = 32,
    parameter int LANE  = 0
) (
    input  logic [LANES*DW-1:0] src,
    input  logic [DW-1:0]       old_val,
    input  xfer_op_e            op,
    input  logic [3:0]          amt,
    input  logic                narrow,
    input  logic                bound_zero,
    output logic [DW-1:0]       val,
    output logic                ok
);
    localparam int HALF  = LANES / 2;
    localparam bit UPPER = (LANE >= HALF);

    lane_pick_t pk;

    always_comb begin
        pk = pick_source(LANE, op, amt, narrow, LANES);
        if (narrow && UPPER) begin
            val = '0;
            ok  = 1'b0;
        end else if (pk.has) begin
            val = src[int'(pk.idx)*DW +: DW];
            ok  = 1'b1;
        end else begin
            ok  = 1'b0;
            val = bound_zero ? '0 : old_val;
        end
    end
endmodule

// File: rtl/lxn_stage_reg.sv
module lxn_stage_reg #(
    parameter int LANES = 64,
    parameter int DW    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                d_vld,
    input  logic [LANES*DW-1:0] d_res,
    input  logic [LANES-1:0]    d_ok,
    output logic                q_vld,
    output logic [LANES*DW-1:0] q_res,
    output logic [LANES-1:0]    q_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld <= 1'b0;
            q_res <= '0;
            q_ok  <= '0;
        end else begin
            q_vld <= d_vld;
            q_res <= d_res;
            q_ok  <= d_ok;
        end
    end
endmodule

// File: rtl/lane_xfer_net.sv
module lane_xfer_net
    import lxn_pkg::*;
#(
    parameter int LANES = 64,
    parameter int DW    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic [2:0]          op_code,
    input  logic [3:0]          amt,
    input  logic                narrow,
    input  logic                bound_zero,
    input  logic [LANES*DW-1:0] src,
    input  logic [LANES*DW-1:0] old_dst,
    output logic                out_vld,
    output logic [LANES*DW-1:0] res,
    output logic [LANES-1:0]    lane_ok
);
    xfer_op_e            op;
    logic [LANES*DW-1:0] nxt_res;
    logic [LANES-1:0]    nxt_ok;

    assign op = xfer_op_e'(op_code);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lxn_lane_mux #(.LANES(LANES), .DW(DW), .LANE(g)) u_mux (
            .src        (src),
            .old_val    (old_dst[g*DW +: DW]),
            .op         (op),
            .amt        (amt),
            .narrow     (narrow),
            .bound_zero (bound_zero),
            .val        (nxt_res[g*DW +: DW]),
            .ok         (nxt_ok[g])
        );
    end

    lxn_stage_reg #(.LANES(LANES), .DW(DW)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .d_vld (in_vld),
        .d_res (nxt_res),
        .d_ok  (nxt_ok),
        .q_vld (out_vld),
        .q_res (res),
        .q_ok  (lane_ok)
    );
endmodule

// File: rtl/lxn_chk.sv
module lxn_chk #(
    parameter int LANES = 64,
    parameter int DW    = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                in_vld,
    input logic [2:0]          op_code,
    input logic [3:0]          amt,
    input logic                narrow,
    input logic                bound_zero,
    input logic [LANES*DW-1:0] src,
    input logic [LANES*DW-1:0] old_dst,
    input logic                out_vld,
    input logic [LANES*DW-1:0] res,
    input logic [LANES-1:0]    lane_ok
);
    localparam int HALF = LANES / 2;

    logic primed;
    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    // R1
    vld_delay_chk: assert property (@(posedge clk) disable iff (rst)
        primed |-> (out_vld == $past(in_vld)));

    // R2
    pass_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op_code) == 3'd0) |->
            (res[HALF*DW-1:0] == $past(src[HALF*DW-1:0]) && lane_ok[HALF-1:0] == '1));

    // R3
    shr_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op_code) == 3'd1 && $past(amt) != 4'd0) |-> !lane_ok[0]);

    // R5
    ror_full_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op_code) == 3'd3) |-> (lane_ok[HALF-1:0] == '1));

    // R9
    rol_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op_code) == 3'd7 && !$past(narrow)) |->
            (res[LANES*DW-1 -: DW] == $past(src[DW-1:0])));

    // R10
    fill_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(bound_zero) && !lane_ok[0]) |-> (res[DW-1:0] == '0));

    // R11
    narrow_top_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(narrow)) |->
            (lane_ok[LANES-1:HALF] == '0 && res[LANES*DW-1:HALF*DW] == '0));
endmodule

bind lane_xfer_net lxn_chk #(.LANES(LANES), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op_code(op_code), .amt(amt),
    .narrow(narrow), .bound_zero(bound_zero), .src(src), .old_dst(old_dst),
    .out_vld(out_vld), .res(res), .lane_ok(lane_ok)
);

// File: tb/sim_lane_xfer_net.sv
`timescale 1ns/1ps
module sim_lane_xfer_net;
    localparam int LANES = 64;
    localparam int DW    = 32;

    logic                clk = 1'b0;
    logic                rst;
    logic                in_vld;
    logic [2:0]          op_code;
    logic [3:0]          amt;
    logic                narrow;
    logic                bound_zero;
    logic [LANES*DW-1:0] src;
    logic [LANES*DW-1:0] old_dst;
    logic                out_vld;
    logic [LANES*DW-1:0] res;
    logic [LANES-1:0]    lane_ok;

    logic [LANES*DW-1:0] exp_res;
    logic [LANES-1:0]    exp_ok;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lane_xfer_net #(.LANES(LANES), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .op_code(op_code), .amt(amt),
        .narrow(narrow), .bound_zero(bound_zero), .src(src), .old_dst(old_dst),
        .out_vld(out_vld), .res(res), .lane_ok(lane_ok)
    );

    function automatic string op_tag(int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Expected result from the requirements, lane by lane.
    task automatic build_expect();
        int nl;
        nl = narrow ? 32 : 64;
        for (int i = 0; i < LANES; i++) begin
            int r, p, j, n;
            r = i / 16; p = i % 16; n = int'(amt); j = -1;
            if (i >= nl) begin
                exp_res[i*DW +: DW] = '0;
                exp_ok[i] = 1'b0;
                continue;
            end
            case (int'(op_code))
                0: j = i;
                1: if (p >= n) j = i - n;
                2: if (p + n <= 15) j = i + n;
                3: j = r * 16 + ((p + 16 - n) % 16);
                4: if (r >= 1) j = 16 * r - 1;
                5: if (r >= 2) j = 31;
                6: if (i >= 1) j = i - 1;
                default: j = (i == nl - 1) ? 0 : i + 1;
            endcase
            if (j >= 0) begin
                exp_res[i*DW +: DW] = src[j*DW +: DW];
                exp_ok[i] = 1'b1;
            end else begin
                exp_res[i*DW +: DW] = bound_zero ? '0 : old_dst[i*DW +: DW];
                exp_ok[i] = 1'b0;
            end
        end
    endtask

    task automatic compare(string tag);
        checks++;
        if (out_vld !== 1'b1) begin
            errors++;
            $display("FAIL R1 out_vld act=%b exp=1", out_vld);
        end
        checks++;
        if (lane_ok !== exp_ok) begin
            errors++;
            $display("FAIL %s/R10 lane_ok act=%h exp=%h", tag, lane_ok, exp_ok);
        end
        checks++;
        if (res !== exp_res) begin
            errors++;
            for (int i = 0; i < LANES; i++)
                if (res[i*DW +: DW] !== exp_res[i*DW +: DW]) begin
                    $display("FAIL %s res lane %0d act=%h exp=%h", tag, i,
                             res[i*DW +: DW], exp_res[i*DW +: DW]);
                    break;
                end
        end
    endtask

    task automatic rand_data();
        for (int i = 0; i < LANES; i++) begin
            src[i*DW +: DW]     = $urandom;
            old_dst[i*DW +: DW] = $urandom;
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge.
    task automatic apply(int op, int n, bit nar, bit bz);
        op_code = 3'(op); amt = 4'(n); narrow = nar; bound_zero = bz;
        in_vld = 1'b1;
        rand_data();
        build_expect();
        @(negedge clk);
        compare(nar ? {op_tag(op), "/R11"} : op_tag(op));
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1a2b));
        rst = 1'b1; in_vld = 1'b0; op_code = '0; amt = '0; narrow = 1'b0;
        bound_zero = 1'b0; src = '0; old_dst = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_vld !== 1'b0 || lane_ok !== '0 || res !== '0) begin
            errors++;
            $display("FAIL R1 reset act=%b/%h exp=0/0", out_vld, lane_ok);
        end
        rst = 1'b0;

        // Directed corners for every move, both fills, both widths
        for (int op = 0; op < 8; op++)
            for (int k = 0; k < 4; k++) begin
                apply(op, (k == 0) ? 1 : (k == 1) ? 15 : (k == 2) ? 0 : 7,
                      k[0], k[1]);
            end
        // R11: upper inputs must not reach the lower lanes in narrow mode
        apply(7, 0, 1'b1, 1'b0);
        apply(5, 0, 1'b1, 1'b1);

        // Random mix
        for (int t = 0; t < 300; t++)
            apply($urandom_range(0, 7), $urandom_range(0, 15),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

        // R1: out_vld drops one cycle after in_vld drops
        in_vld = 1'b0;
        @(negedge clk);
        checks++;
        if (out_vld !== 1'b0) begin
            errors++;
            $display("FAIL R1 out_vld act=%b exp=0", out_vld);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule